// File: doc/BRIEF.md
# Flow-Through Synchronous Burst Cache RAM

This block models a 32-bit-wide synchronous cache memory with four byte lanes. Address, chip selects and control strobes are registered on the rising clock edge. Read data is then produced combinationally from the registered address in the same cycle, with no output register stage. Two address strobes can open an access: a processor strobe and a controller strobe. The processor strobe has priority, and it only counts when the first chip select is active. A two-bit beat counter lets one access run as a four-beat burst that wraps within its aligned group of four words.

The shared data bus is split into a data-in port, a data-out port and an output-enable flag. The output enable stands in for the tri-state pad that would sit outside the block. A sleep input freezes the block and drops the output. Depth is a parameter and is kept small by default.

Top module: `fts_sram`

## Requirements
- R1: An access opens on a clock edge only when `sel_a_n` is low, `sel_b` is high, `sel_c_n` is low and at least one strobe (`proc_strobe_n` or `ctrl_strobe_n`) is low. A strobe with any select inactive deselects the block. While deselected, cycles with no strobe leave `q_oe_o` low.
- R2: When both strobes are low on the same edge, the processor strobe governs. The cycle is therefore a read, whatever the write controls say.
- R3: A low `proc_strobe_n` while `sel_a_n` is high gives a deselected cycle. No data is written and `q_oe_o` goes low.
- R4: An opening strobe loads the full address. On later edges with no strobe, `burst_step_n` low moves the beat (address bits [1:0]) to the next value. The sequence is linear and wraps from 3 to 0 while the upper bits stay the same.
- R5: On an edge with no strobe, `burst_step_n` high keeps the current address.
- R6: On the edge where the processor strobe opens an access, the write controls are ignored and the cycle reads. A write on the next edge, with the address held, stores to that address.
- R7: The write lane mask works as follows. `wr_all_n` low writes all four lanes. Otherwise, with `lane_wr_en_n` low, each low bit `lane_sel_n[i]` writes data bits [8i+7:8i]. Otherwise the cycle is a read, and this includes the case where all `lane_sel_n` bits are high.
- R8: In the cycle that follows the edge registering a read address, `q_o` carries the word stored at that address.
- R9: `q_oe_o` is high only during a read cycle of an open access with `out_en_n` low and `sleep` low. It is low in the cycle after a write.
- R10: While `sleep` is high, all other inputs are ignored and `q_oe_o` is low. After sleep the block is deselected until a new strobe opens an access.
- R11: Reset (`rst_n` low, asynchronous) deselects the block and forces `q_oe_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | AW | Word address, AW = clog2(DEPTH) |
| proc_strobe_n | input | 1 | Processor address strobe, active low, higher priority |
| ctrl_strobe_n | input | 1 | Controller address strobe, active low |
| burst_step_n | input | 1 | Advance beat when low, hold when high |
| wr_all_n | input | 1 | Write all lanes, active low |
| lane_wr_en_n | input | 1 | Enable per-lane writes, active low |
| lane_sel_n | input | 4 | Per-lane write selects, active low |
| sel_a_n | input | 1 | Chip select A, active low; also gates the processor strobe |
| sel_b | input | 1 | Chip select B, active high |
| sel_c_n | input | 1 | Chip select C, active low |
| out_en_n | input | 1 | Output enable, active low |
| sleep | input | 1 | Sleep request, active high |
| d_i | input | 32 | Write data |
| q_o | output | 32 | Read data from the registered address |
| q_oe_o | output | 1 | Drive enable for read data |

## Verification
Every result appears in the cycle right after the clock edge that samples its stimulus. Writes, address loads and beat steps take effect at that edge. `q_o` then follows the new registered address combinationally. `q_oe_o` also depends combinationally on the `out_en_n` and `sleep` values held through that cycle. The bench changes inputs on the falling edge and samples a quarter period after the next rising edge, so each check sees exactly one edge's effect. Write results are confirmed by a later read vector, one cycle after that read's own edge.

// File: rtl/fts_pkg.sv
package fts_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int DATA_W = LANES * LANE_W;

  // Lane write mask from the global and per-lane write controls.
  function automatic logic [LANES-1:0] lane_mask(input logic all_n,
                                                 input logic lane_en_n,
                                                 input logic [LANES-1:0] sel_n);
    if (!all_n)          return '1;
    else if (!lane_en_n) return ~sel_n;
    else                 return '0;
  endfunction

  // Next beat inside an aligned group of four words (linear, wrapping).
  function automatic logic [1:0] beat_next(input logic [1:0] beat, input logic step);
    return beat + {1'b0, step};
  endfunction
endpackage

// File: rtl/fts_decode.sv
module fts_decode (
  input  logic clk,
  input  logic rst_n,
  input  logic proc_strobe_n,
  input  logic ctrl_strobe_n,
  input  logic sel_a_n,
  input  logic sel_b,
  input  logic sel_c_n,
  input  logic sleep,
  output logic p_start,
  output logic c_start,
  output logic dsel
);
  logic sel_all;
  logic strobe_any;

  assign sel_all    = !sel_a_n && sel_b && !sel_c_n;
  assign strobe_any = !proc_strobe_n || !ctrl_strobe_n;

  // Processor strobe wins; it can only open when sel_a_n is low (inside sel_all).
  assign p_start = !sleep && strobe_any && sel_all && !proc_strobe_n;
  assign c_start = !sleep && strobe_any && sel_all && proc_strobe_n;
  assign dsel    = !sleep && strobe_any && !sel_all;

  assert_one_event_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({p_start, c_start, dsel}) <= 1);
  assert_proc_prio_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!proc_strobe_n && !ctrl_strobe_n && !sleep) |-> !c_start);
endmodule

// File: rtl/fts_burst.sv
module fts_burst
  import fts_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sleep,
  input  logic          start,
  input  logic          dsel,
  input  logic          step,
  input  logic          wr_fire,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] cur_addr,
  output logic [AW-1:0] eff_addr,
  output logic          eff_act,
  output logic          act,
  output logic          rd
);
  localparam int BW = AW - 2;

  logic [BW-1:0] base_q;
  logic [1:0]    beat_q;

  assign cur_addr = {base_q, beat_q};
  assign eff_act  = start || (act && !dsel);
  assign eff_addr = start ? addr_i : {base_q, beat_next(beat_q, step)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act    <= 1'b0;
      rd     <= 1'b0;
      base_q <= '0;
      beat_q <= '0;
    end else if (sleep) begin
      act <= 1'b0;
      rd  <= 1'b0;
    end else begin
      act    <= eff_act;
      rd     <= eff_act && !wr_fire;
      base_q <= eff_addr[AW-1:2];
      beat_q <= eff_addr[1:0];
    end
  end

  assert_beat_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !start && step && beat_q == 2'd3) |=> (beat_q == 2'd0 && $stable(base_q)));
  assert_hold_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !start && !step) |=> $stable(cur_addr));
  assert_sleep_dsel_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> (!act && !rd));
endmodule

// File: rtl/fts_array.sv
module fts_array
  import fts_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input  logic              clk,
  input  logic [LANES-1:0]  we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we[l]) mem[waddr] <= wdata[l*LANE_W +: LANE_W];
    end
    assign rdata[l*LANE_W +: LANE_W] = mem[raddr];
  end
endmodule

// File: rtl/fts_sram.sv
module fts_sram
  import fts_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(DEPTH)-1:0] addr_i,
  input  logic                     proc_strobe_n,
  input  logic                     ctrl_strobe_n,
  input  logic                     burst_step_n,
  input  logic                     wr_all_n,
  input  logic                     lane_wr_en_n,
  input  logic [3:0]               lane_sel_n,
  input  logic                     sel_a_n,
  input  logic                     sel_b,
  input  logic                     sel_c_n,
  input  logic                     out_en_n,
  input  logic                     sleep,
  input  logic [31:0]              d_i,
  output logic [31:0]              q_o,
  output logic                     q_oe_o
);
  localparam int AW = $clog2(DEPTH);

  logic p_start, c_start, dsel, start;
  logic eff_act, act, rd, wr_fire;
  logic [AW-1:0] cur_addr, eff_addr;
  logic [LANES-1:0] wr_mask, we;

  fts_decode u_dec (
    .clk(clk), .rst_n(rst_n),
    .proc_strobe_n(proc_strobe_n), .ctrl_strobe_n(ctrl_strobe_n),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .sleep(sleep),
    .p_start(p_start), .c_start(c_start), .dsel(dsel)
  );

  assign start   = p_start || c_start;
  assign wr_mask = lane_mask(wr_all_n, lane_wr_en_n, lane_sel_n);
  assign wr_fire = eff_act && !sleep && !p_start && (|wr_mask);
  assign we      = wr_fire ? wr_mask : '0;

  fts_burst #(.AW(AW)) u_burst (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .start(start), .dsel(dsel),
    .step(!burst_step_n), .wr_fire(wr_fire), .addr_i(addr_i),
    .cur_addr(cur_addr), .eff_addr(eff_addr), .eff_act(eff_act),
    .act(act), .rd(rd)
  );

  fts_array #(.DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk(clk), .we(we), .waddr(eff_addr), .wdata(d_i),
    .raddr(cur_addr), .rdata(q_o)
  );

  assign q_oe_o = act && rd && !out_en_n && !sleep;

  assert_dsel_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dsel |=> !q_oe_o);
  assert_proc_reads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (p_start && !ctrl_strobe_n) |=> rd);
  assert_proc_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!proc_strobe_n && sel_a_n && !sleep) |=> !act);
  assert_first_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    p_start |-> (we == '0));
  assert_write_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> !q_oe_o);
  assert_sleep_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (we == '0));
endmodule

// File: tb/tb_fts_sram.sv
module tb_fts_sram;
  localparam int CLK_PER = 10;
  localparam int DEPTH   = 64;

  typedef struct packed {
    logic ps, cs, av, gw, bwe;
    logic [3:0] bw;
    logic c1, c2, c3, oe, zz;
    logic [5:0]  a;
    logic [31:0] d;
    logic        xoe;
    logic [31:0] xq;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VEC [NV] = '{
    // ps  cs  av  gw  bwe bw     c1  c2  c3  oe  zz  a     d              xoe xq            req
    '{1'b1,1'b0,1'b1,1'b0,1'b1,4'hF,1'b0,1'b1,1'b0,1'b0,1'b0,6'd7,32'h77777777,1'b0,32'h0,       4'd7}, // R7 full write 7
    '{1'b1,1'b0,1'b1,1'b0,1'b1,4'hF,1'b0,1'b1,1'b0,1'b0,1'b0,6'd4,32'hA0A00004,1'b0,32'h0,       4'd7}, // R7 full write 4
    '{1'b1,1'b0,1'b1,1'b1,1'b0,4'h0,1'b0,1'b1,1'b0,1'b0,1'b0,6'd5,32'hB0B00005,1'b0,32'h0,       4'd7}, // R7 all lanes via selects
    '{1'b1,1'b0,1'b1,1'b0,1'b1,4'hF,1'b0,1'b1,1'b0,1'b0,1'b0,6'd6,32'h11223344,1'b0,32'h0,       4'd7}, // R7
    '{1'b1,1'b0,1'b1,1'b1,1'b0,4'hA,1'b0,1'b1,1'b0,1'b0,1'b0,6'd6,32'hAABBCCDD,1'b0,32'h0,       4'd7}, // R7 lanes 0,2
    '{1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,1'b0,1'b1,1'b0,1'b0,1'b0,6'd4,32'h0,       1'b1,32'hA0A00004,4'd8}, // R8 read 4
    '{1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b0,1'b1,1'b0,1'b0,1'b0,6'd0,32'h0,       1'b1,32'hB0B00005,4'd4}, // R4 beat 5
    '{1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b0,1'b1,1'b0,1'b0,1'b0,6'd0,32'h0,       1'b1,32'h11BB33DD,4'd4}, // R4 beat 6, R7 merge
    '{1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b0,1'b1,1'b0,1'b0,1'b0,6'd0,32'h0,       1'b1,32'h77777777,4'd4}, // R4 beat 7
    '{1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b0,1'b1,1'b0,1'b0,1'b0,6'd0,32'h0,       1'b1,32'hA0A00004,4'd4}, // R4 wrap to 4
    '{1'b1,1'b1,1'b1,1'b1,1'b1,4'hF,1'b0,1'b1,1'b0,1'b0,1'b0,6'd0,32'h0,       1'b1,32'hA0A00004,4'd5}, // R5 hold
    '{1'b0,1'b1,1'b1,1'b0,1'b1,4'hF,1'b0,1'b1,1'b0,1'b0,1'b0,6'd5,32'hDEADBEEF,1'b1,32'hB0B00005,4'd6}, // R6 first cycle reads
    '{1'b1,1'b1,1'b1,1'b0,1'b1,4'hF,1'b0,1'b1,1'b0,1'b0,1'b0,6'd0,32'hCAFEF00D,1'b0,32'h0,       4'd6}, // R6 write next cycle
    '{1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,1'b0,1'b1,1'b0,1'b0,1'b0,6'd5,32'h0,       1'b1,32'hCAFEF00D,4'd6}, // R6 readback
    '{1'b0,1'b0,1'b1,1'b0,1'b1,4'hF,1'b0,1'b1,1'b0,1'b0,1'b0,6'd4,32'h12345678,1'b1,32'hA0A00004,4'd2}, // R2 both strobes
    '{1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,1'b0,1'b1,1'b0,1'b0,1'b0,6'd4,32'h0,       1'b1,32'hA0A00004,4'd2}, // R2 no write happened
    '{1'b0,1'b1,1'b1,1'b0,1'b1,4'hF,1'b1,1'b1,1'b0,1'b0,1'b0,6'd4,32'h0,       1'b0,32'h0,       4'd3}, // R3 gated strobe
    '{1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,1'b0,1'b1,1'b0,1'b0,1'b0,6'd4,32'h0,       1'b1,32'hA0A00004,4'd3}, // R3 no write happened
    '{1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,1'b0,1'b0,1'b0,1'b0,1'b0,6'd6,32'h0,       1'b0,32'h0,       4'd1}, // R1 sel_b low
    '{1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b0,1'b1,1'b0,1'b0,1'b0,6'd0,32'h0,       1'b0,32'h0,       4'd1}, // R1 stays deselected
    '{1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,1'b0,1'b1,1'b0,1'b1,1'b0,6'd6,32'h0,       1'b0,32'h0,       4'd9}, // R9 out_en_n high
    '{1'b1,1'b1,1'b1,1'b1,1'b1,4'hF,1'b0,1'b1,1'b0,1'b0,1'b0,6'd0,32'h0,       1'b1,32'h11BB33DD,4'd9}, // R9 enabled
    '{1'b1,1'b0,1'b1,1'b0,1'b1,4'hF,1'b0,1'b1,1'b0,1'b0,1'b1,6'd4,32'h0,       1'b0,32'h0,       4'd10},// R10 sleep, write ignored
    '{1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b0,1'b1,1'b0,1'b0,1'b0,6'd0,32'h0,       1'b0,32'h0,       4'd10},// R10 deselected after
    '{1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,1'b0,1'b1,1'b0,1'b0,1'b0,6'd4,32'h0,       1'b1,32'hA0A00004,4'd10},// R10 data kept
    '{1'b1,1'b0,1'b1,1'b1,1'b0,4'hF,1'b0,1'b1,1'b0,1'b0,1'b0,6'd7,32'h0,       1'b1,32'h77777777,4'd7}, // R7 no lane selected
    '{1'b1,1'b0,1'b1,1'b1,1'b1,4'h0,1'b0,1'b1,1'b0,1'b0,1'b0,6'd7,32'h0,       1'b1,32'h77777777,4'd7}, // R7 lane enable off
    '{1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,1'b0,1'b1,1'b1,1'b0,1'b0,6'd7,32'h0,       1'b0,32'h0,       4'd1}, // R1 sel_c_n high
    '{1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,1'b0,1'b1,1'b0,1'b0,1'b0,6'd4,32'h0,       1'b1,32'hA0A00004,4'd1}  // R1 all selects
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] addr_i = '0;
  logic ps = 1'b1, cs = 1'b1, av = 1'b1, gw = 1'b1, bwe = 1'b1;
  logic [3:0] bw = 4'hF;
  logic c1 = 1'b0, c2 = 1'b1, c3 = 1'b0, oe = 1'b0, zz = 1'b0;
  logic [31:0] d_i = '0;
  logic [31:0] q_o;
  logic q_oe_o;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  fts_sram #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i),
    .proc_strobe_n(ps), .ctrl_strobe_n(cs), .burst_step_n(av),
    .wr_all_n(gw), .lane_wr_en_n(bwe), .lane_sel_n(bw),
    .sel_a_n(c1), .sel_b(c2), .sel_c_n(c3), .out_en_n(oe), .sleep(zz),
    .d_i(d_i), .q_o(q_o), .q_oe_o(q_oe_o)
  );

  task automatic check(input int rq, input logic xoe, input logic [31:0] xq, input string tag);
    total++;
    if (q_oe_o !== xoe || (xoe && q_o !== xq)) begin
      bad++;
      $display("FAIL R%0d %s: actual oe=%b q=%h expected oe=%b q=%h", rq, tag, q_oe_o, q_o, xoe, xq);
    end
  endtask

  task automatic drive(input vec_t v);
    ps = v.ps; cs = v.cs; av = v.av; gw = v.gw; bwe = v.bwe; bw = v.bw;
    c1 = v.c1; c2 = v.c2; c3 = v.c3; oe = v.oe; zz = v.zz; addr_i = v.a; d_i = v.d;
  endtask

  initial begin
    // R11: reset holds the output off even with a read requested
    cs = 1'b0; addr_i = 6'd4;
    repeat (3) @(posedge clk);
    #(CLK_PER/4);
    check(11, 1'b0, 32'h0, "in reset R11");
    @(negedge clk);
    cs = 1'b1;
    rst_n = 1'b1;
    @(posedge clk);
    #(CLK_PER/4);
    check(11, 1'b0, 32'h0, "after reset R11");

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      @(posedge clk);
      #(CLK_PER/4);
      check(int'(VEC[i].req), VEC[i].xoe, VEC[i].xq, $sformatf("vector %0d", i));
    end

    // R11: asynchronous reset in the middle of an open read
    @(negedge clk);
    ps = 1'b1; cs = 1'b1; av = 1'b1;
    @(posedge clk);
    #(CLK_PER/4);
    check(5, 1'b1, 32'hA0A00004, "hold before reset R5");
    rst_n = 1'b0;
    #1;
    check(11, 1'b0, 32'h0, "mid-access reset R11");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog (all R): actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule